// File: doc/BRIEF.md
# Speculative Two-Slot Read Scheduler

This block sits on the controller side of a memory channel whose data bus is cut into fixed slots. Each slot is long enough to move one cache line. The controller is the only owner of that bus. A slot counter steps once per clock, so one slot period equals one clock. Reservations live in a circular bitmap of `SLOTS` future slots, and each bit is indexed by the absolute slot number modulo `SLOTS`.

A read request arrives with three things: an address, a tag, and a latency `req_lat` in slots. The memory side supplies that latency; it is the sum of address transfer, array access and bus transfer. No search starts before the arrival slot plus that latency. The block books the first free slot from there on as the primary slot. It also books a backup slot, which is the first free slot at least `GAP` slots after the primary one. Only the address goes out to the memory side. The memory side then reports per tag whether the data made the awaited slot:
- A hit on the primary slot frees the backup slot for later requests.
- A miss on the primary slot leaves the request waiting on its backup slot.
- A miss on the backup slot turns into a retry notice.

When either slot cannot be found inside the window, the request input stalls. It also stalls while the tag is still outstanding.

Top module: `slot_reserve_sched`

## Requirements
- R1: `slot_now` is 0 after reset and increases by one (modulo `SLOTS`) on every clock.
- R2: An accepted request's primary slot is `slot_now` at acceptance plus the smallest offset k with k ≥ max(`req_lat`,1), k ≤ `SLOTS`-1, whose slot is unreserved. It is reported as `grant_pri` together with `grant_tag` one clock after acceptance.
- R3: The backup slot (`grant_bak`) is the first unreserved offset at least `GAP` beyond the primary offset, and no further than `SLOTS`-1 from `slot_now`.
- R4: `req_ready` is high exactly when both a primary and a backup slot exist and `req_tag` has no outstanding request. `grant_valid` rises only for an accepted request.
- R5: With each grant, `mem_valid` is high in the same cycle and `mem_addr` carries the accepted address.
- R6: A report with `rsp_ok`=1 for a request still waiting on its primary slot releases that request's backup slot, so a later request can be given it.
- R7: A release and a new search in the same clock see the release first: the new request can be given the slot freed in that very clock.
- R8: A report with `rsp_ok`=0 for a request waiting on its backup slot raises `retry_valid` with `retry_tag` one clock later and frees the tag. A report with `rsp_ok`=0 on the primary slot only moves the request to its backup slot.
- R9: During reset, `grant_valid`, `mem_valid` and `retry_valid` are low. With an empty map and `req_lat`=1, `req_ready` is high.
- R10: A slot's reservation is dropped once the counter passes it, so the slot can be booked again after the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | ADDR_W | Read address |
| req_tag | input | TAG_W | Request tag |
| req_lat | input | log2(SLOTS) | Memory latency in slots |
| rsp_valid | input | 1 | Readiness report from the memory side |
| rsp_tag | input | TAG_W | Tag the report refers to |
| rsp_ok | input | 1 | 1: data present in the awaited slot |
| slot_now | output | log2(SLOTS) | Current slot number |
| grant_valid | output | 1 | Reservation made |
| grant_tag | output | TAG_W | Tag of the reservation |
| grant_pri | output | log2(SLOTS) | Primary slot number |
| grant_bak | output | log2(SLOTS) | Backup slot number |
| mem_valid | output | 1 | Address sent to memory side |
| mem_addr | output | ADDR_W | Address to memory side |
| retry_valid | output | 1 | Request missed both slots |
| retry_tag | output | TAG_W | Tag to retry |

## Verification
The sharp case is a primary-hit report that frees a backup slot in the same clock as a new request whose search begins exactly at that slot. The bench sends request A, waits until A's primary slot is current, and in that clock issues both A's hit report and request B with a latency that points at A's backup. The check is that B's primary equals A's former backup slot. Random traffic mixes both kinds of event with stalls and wrap-around, and a reference bitmap in the bench judges every cycle.

// File: rtl/slot_reserve_sched.sv
module slot_reserve_sched #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4,
  parameter int SLOTS  = 64,
  parameter int GAP    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [TAG_W-1:0]         req_tag,
  input  logic [$clog2(SLOTS)-1:0] req_lat,
  input  logic                     rsp_valid,
  input  logic [TAG_W-1:0]         rsp_tag,
  input  logic                     rsp_ok,
  output logic [$clog2(SLOTS)-1:0] slot_now,
  output logic                     grant_valid,
  output logic [TAG_W-1:0]         grant_tag,
  output logic [$clog2(SLOTS)-1:0] grant_pri,
  output logic [$clog2(SLOTS)-1:0] grant_bak,
  output logic                     mem_valid,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     retry_valid,
  output logic [TAG_W-1:0]         retry_tag
);
  localparam int SW   = $clog2(SLOTS);
  localparam int NTAG = 1 << TAG_W;

  logic [SLOTS-1:0]   rsv, rsv_eff, win;
  logic [2*SLOTS-1:0] dbl;
  logic [NTAG-1:0]    live, late;
  logic [SW-1:0]      bak_q [NTAG];
  logic               hit, drop_bak, fire, p_ok, b_ok;
  logic [SW-1:0]      p_off, b_off, p_abs, b_abs;

  // R6/R7: a primary hit frees the backup bit before the search sees the map
  assign hit      = rsp_valid && live[rsp_tag];
  assign drop_bak = hit && !late[rsp_tag] && rsp_ok;
  assign rsv_eff  = drop_bak ? (rsv & ~(SLOTS'(1) << bak_q[rsp_tag])) : rsv;
  assign dbl      = {rsv_eff, rsv_eff};
  assign win      = dbl[slot_now +: SLOTS];

  // R2/R3: offset 0 is the slot in progress and is never offered
  always_comb begin
    p_ok  = 1'b0;
    b_ok  = 1'b0;
    p_off = '0;
    b_off = '0;
    for (int k = 1; k < SLOTS; k++)
      if (!p_ok && k >= int'(req_lat) && !win[k]) begin
        p_ok  = 1'b1;
        p_off = SW'(k);
      end
    for (int k = 1; k < SLOTS; k++)
      if (p_ok && !b_ok && k >= int'(p_off) + GAP && !win[k]) begin
        b_ok  = 1'b1;
        b_off = SW'(k);
      end
  end

  assign req_ready = p_ok && b_ok && !live[req_tag];
  assign fire      = req_valid && req_ready;
  assign p_abs     = slot_now + p_off;
  assign b_abs     = slot_now + b_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_now    <= '0;
      rsv         <= '0;
      live        <= '0;
      late        <= '0;
      grant_valid <= 1'b0;
      grant_tag   <= '0;
      grant_pri   <= '0;
      grant_bak   <= '0;
      mem_valid   <= 1'b0;
      mem_addr    <= '0;
      retry_valid <= 1'b0;
      retry_tag   <= '0;
      for (int i = 0; i < NTAG; i++) bak_q[i] <= '0;
    end else begin
      slot_now <= slot_now + 1'b1;
      // R10: the slot in progress leaves the map as the counter moves on
      rsv <= (rsv_eff & ~(SLOTS'(1) << slot_now))
           | (fire ? ((SLOTS'(1) << p_abs) | (SLOTS'(1) << b_abs)) : '0);
      if (hit) begin
        if (late[rsp_tag] || rsp_ok) live[rsp_tag] <= 1'b0;
        else                         late[rsp_tag] <= 1'b1;
      end
      if (fire) begin
        live[req_tag]  <= 1'b1;
        late[req_tag]  <= 1'b0;
        bak_q[req_tag] <= b_abs;
      end
      grant_valid <= fire;
      grant_tag   <= req_tag;
      grant_pri   <= p_abs;
      grant_bak   <= b_abs;
      mem_valid   <= fire;
      mem_addr    <= req_addr;
      // R8: a miss on the backup slot ends in a retry notice
      retry_valid <= hit && late[rsp_tag] && !rsp_ok;
      retry_tag   <= rsp_tag;
    end
  end
endmodule

// File: rtl/slot_reserve_sched_chk.sv
module slot_reserve_sched_chk #(
  parameter int SW  = 6,
  parameter int GAP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [SW-1:0] req_lat,
  input logic [SW-1:0] slot_now,
  input logic          grant_valid,
  input logic [SW-1:0] grant_pri,
  input logic [SW-1:0] grant_bak,
  input logic          mem_valid,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic          retry_valid
);
  assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> slot_now == SW'($past(slot_now) + 1'b1));

  assert_pri_after_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (SW'(grant_pri - $past(slot_now)) >= $past(req_lat)) &&
      (SW'(grant_pri - $past(slot_now)) != '0));

  assert_bak_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> SW'(grant_bak - grant_pri) >= SW'(GAP));

  assert_no_grant_unaccepted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !grant_valid);

  assert_addr_with_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> grant_valid && mem_valid);

  assert_retry_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retry_valid |-> $past(rsp_valid && !rsp_ok));
endmodule

bind slot_reserve_sched slot_reserve_sched_chk #(.SW(SW), .GAP(GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_lat(req_lat), .slot_now(slot_now), .grant_valid(grant_valid),
  .grant_pri(grant_pri), .grant_bak(grant_bak), .mem_valid(mem_valid),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .retry_valid(retry_valid)
);

// File: tb/slot_reserve_sched_test.sv
`timescale 1ns/1ps
module slot_reserve_sched_test;
  localparam int AW = 32, TW = 4, NS = 64, G = 4, NT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_ready, rsp_valid = 0, rsp_ok = 0;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [TW-1:0] req_tag = '0, rsp_tag = '0, grant_tag, retry_tag;
  logic [5:0]    req_lat = 6'd1, slot_now, grant_pri, grant_bak;
  logic          grant_valid, mem_valid, retry_valid;

  slot_reserve_sched #(.ADDR_W(AW), .TAG_W(TW), .SLOTS(NS), .GAP(G)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_tag(req_tag), .req_lat(req_lat),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_ok(rsp_ok),
    .slot_now(slot_now), .grant_valid(grant_valid), .grant_tag(grant_tag),
    .grant_pri(grant_pri), .grant_bak(grant_bak), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .retry_valid(retry_valid), .retry_tag(retry_tag));

  int tests = 0, fails = 0;
  bit done = 0;
  bit [NS-1:0] mmap = '0;
  longint mtime = 0, last_t = 0;
  bit mlive[NT], mlate[NT];
  longint mpri[NT], mbak[NT];

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // okmode: 0 report miss, 1 report hit, 2 random
  task automatic step(input bit rv, input logic [AW-1:0] ad, input int tg, input int lat, input int okmode);
    bit [NS-1:0] tmp;
    int p, b, rt;
    bit pf, bf, er, fire, rvd, rok, exp_retry;
    @(negedge clk);
    rvd = 0; rt = 0;
    for (int t = 0; t < NT; t++)
      if (!rvd && mlive[t] && ((!mlate[t] && mpri[t] == mtime) || (mlate[t] && mbak[t] == mtime))) begin
        rvd = 1; rt = t;
      end
    rok = (okmode == 2) ? ($urandom % 4 != 0) : (okmode == 1);
    req_valid = rv; req_addr = ad; req_tag = TW'(tg); req_lat = 6'(lat);
    rsp_valid = rvd; rsp_tag = TW'(rt); rsp_ok = rok;
    #1;
    tmp = mmap;
    if (rvd && !mlate[rt] && rok) tmp[int'(mbak[rt] % NS)] = 1'b0;
    pf = 0; bf = 0; p = 0; b = 0;
    for (int k = 1; k < NS; k++)
      if (!pf && k >= lat && !tmp[int'((mtime + k) % NS)]) begin pf = 1; p = k; end
    for (int k = 1; k < NS; k++)
      if (pf && !bf && k >= p + G && !tmp[int'((mtime + k) % NS)]) begin bf = 1; b = k; end
    er = pf && bf && !mlive[tg];
    chk(req_ready == er, "R4 req_ready", req_ready, er);
    fire = rv && er;
    exp_retry = rvd && mlate[rt] && !rok;
    @(posedge clk); #1;
    mmap = tmp;
    mmap[int'(mtime % NS)] = 1'b0;
    if (rvd) begin
      if (mlate[rt] || rok) mlive[rt] = 0; else mlate[rt] = 1;
    end
    if (fire) begin
      mmap[int'((mtime + p) % NS)] = 1'b1;
      mmap[int'((mtime + b) % NS)] = 1'b1;
      mlive[tg] = 1; mlate[tg] = 0;
      mpri[tg] = mtime + p; mbak[tg] = mtime + b;
    end
    last_t = mtime;
    mtime++;
    chk(slot_now == 6'(mtime % NS), "R1 slot_now", slot_now, mtime % NS);
    chk(grant_valid == fire, "R4 grant_valid", grant_valid, fire);
    chk(mem_valid == fire, "R5 mem_valid", mem_valid, fire);
    if (fire) begin
      chk(grant_tag == TW'(tg), "R2 grant_tag", grant_tag, tg);
      chk(grant_pri == 6'((last_t + p) % NS), "R2 grant_pri", grant_pri, (last_t + p) % NS);
      chk(grant_bak == 6'((last_t + b) % NS), "R3 grant_bak", grant_bak, (last_t + b) % NS);
      chk(mem_addr == ad, "R5 mem_addr", mem_addr, ad);
    end
    chk(retry_valid == exp_retry, "R8 retry_valid", retry_valid, exp_retry);
    if (exp_retry) chk(retry_tag == TW'(rt), "R8 retry_tag", retry_tag, rt);
  endtask

  task automatic idle(input int n, input int okmode);
    for (int i = 0; i < n; i++) step(0, '0, 0, 1, okmode);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    longint t0;
    int r, lat;
    void'($urandom(32'h51a7));
    for (int t = 0; t < NT; t++) begin mlive[t] = 0; mlate[t] = 0; mpri[t] = 0; mbak[t] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(grant_valid == 0, "R9 grant_valid in reset", grant_valid, 0);
    chk(mem_valid == 0, "R9 mem_valid in reset", mem_valid, 0);
    chk(retry_valid == 0, "R9 retry_valid in reset", retry_valid, 0);
    chk(slot_now == 0, "R9 R1 slot_now in reset", slot_now, 0);
    chk(req_ready == 1, "R9 req_ready empty map", req_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2 R3 basic placement
    step(1, 32'h1000, 0, 5, 1);
    chk(grant_pri == 6'((last_t + 5) % NS), "R2 first primary", grant_pri, (last_t + 5) % NS);
    chk(grant_bak == 6'((last_t + 5 + G) % NS), "R3 first backup", grant_bak, (last_t + 5 + G) % NS);
    idle(70, 1);

    // R6 R7: release and search in the same clock
    t0 = mtime;
    step(1, 32'h2000, 1, 5, 1);
    while (mtime < t0 + 5) step(0, '0, 0, 1, 1);
    step(1, 32'h3000, 2, 4, 1);
    chk(grant_valid == 1, "R7 grant on freed slot", grant_valid, 1);
    chk(grant_pri == 6'((t0 + 5 + G) % NS), "R6 R7 reuse of released backup", grant_pri, (t0 + 5 + G) % NS);
    idle(70, 1);

    // R4 stall when no backup fits in the window
    step(1, 32'h4000, 4, 62, 1);
    chk(req_ready == 0 && grant_valid == 0, "R4 stall lat 62", grant_valid, 0);
    step(1, 32'h4004, 4, 63, 1);
    chk(grant_valid == 0, "R4 stall lat 63", grant_valid, 0);

    // R8 miss on both slots, then tag reuse
    t0 = mtime;
    step(1, 32'h5000, 3, 3, 0);
    while (mtime < t0 + 3 + G) step(0, '0, 0, 1, 0);
    step(0, '0, 0, 1, 0);
    chk(retry_valid == 1 && retry_tag == 3, "R8 retry after backup miss", retry_tag, 3);
    step(1, 32'h5100, 3, 2, 1);
    chk(grant_valid == 1, "R8 tag free after retry", grant_valid, 1);
    idle(20, 1);

    // R4 busy tag
    step(1, 32'h6000, 5, 10, 1);
    step(1, 32'h6004, 5, 10, 1);
    chk(grant_valid == 0, "R4 busy tag stalls", grant_valid, 0);
    idle(70, 1);

    // random traffic, wraps the window many times (R10)
    for (int i = 0; i < 4000; i++) begin
      r = $urandom % 8;
      lat = (r == 0) ? 0 : (r == 1) ? 60 + int'($urandom % 4) : 1 + int'($urandom % 30);
      step(($urandom % 3) == 0, $urandom, int'($urandom % NT), lat, 2);
    end
    idle(140, 2);
    chk(mtime > 3 * NS, "R10 window wrapped", mtime, 3 * NS);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule